// File: doc/BRIEF.md
# Scatter-Gather DMA Write Engine

This block drains a 256-bit data stream, one word per beat from a user-logic FIFO, and writes it into host or GPU memory. The destination is a list of up to sixteen physical buffers, each given by a 64-bit start address and a 32-bit byte length. The host fills this list through word-wide programmed-I/O registers and may rewrite any entry that the engine has not reached yet while a transfer runs. Data therefore lands in its final buffers with no copy in between.

A start command makes the engine walk the first N entries in index order, where N is a programmed count. For each entry it cuts the data into write bursts of at most 256 bytes on a simple request channel that carries address, length, start and end markers, and data beats, with a valid/ready handshake. A burst never crosses the end of an entry. After the last data beat it posts one 4-byte notification write, which carries the number of bytes moved, to an address chosen by the host. A cycle counter measures the time from the accepted start command to the stop command with which the host acknowledges the data. One count is one clock period, 4 ns at the intended 250 MHz.

Top module: `sgdma_wr`

## Requirements
- R1: When reset is released, the status register reads 0 (idle), the latency register reads 0, and both req_valid and s_ready are low.
- R2: The programmed-I/O map is: 0x00 control (bit0 start, bit1 stop), 0x01 entry count, 0x02 and 0x03 notification address low and high words, 0x04 status, 0x05 latency, and table words at 0x80+4*i+f for entry i, with f=0 for address low, f=1 for address high and f=2 for byte length. The engine reads an entry only when it reaches that entry, so a rewrite of a later entry during a transfer takes effect, and every table word reads back what was written.
- R3: Entries 0 to count-1 are written in index order. The bursts of one entry start at its address and continue at consecutive addresses. The address and length on the request channel stay stable while a beat waits for req_ready.
- R4: Each burst length in bytes is min(256, bytes left in the entry) and is a nonzero multiple of 32. The burst carries length/32 beats, req_sop marks its first beat and req_eop its last. Entry lengths are nonzero multiples of 32 bytes.
- R5: After the last data beat, and never before it, exactly one write with req_notify=1 is issued to the notification address, with req_len=4 and req_data[31:0] equal to the number of data bytes in the transfer. No data beat follows it.
- R6: s_ready is high only while data is moving and req_ready is high. Every accepted stream word appears as exactly one request beat with identical data, in order, with no loss and no repeat under back-pressure on either side.
- R7: Status bits [1:0] read 0 when idle, 1 when busy and 2 when done, and bits [11:8] hold the current entry index (the last entry used once done). A start while busy is ignored. A start when idle or done begins a new transfer.
- R8: The latency register is cleared by an accepted start, then counts once per clock up to and including the cycle in which stop is written, and holds its value after that.
- R9: With an entry count of 0, a start produces no data bursts and goes straight to the notification write carrying a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pio_we | input | 1 | Register write strobe |
| pio_waddr | input | 8 | Register write address |
| pio_wdata | input | 32 | Register write data |
| pio_raddr | input | 8 | Register read address |
| pio_rdata | output | 32 | Register read data (combinational) |
| s_data | input | 256 | Stream word from the FIFO |
| s_valid | input | 1 | Stream word available |
| s_ready | output | 1 | Stream word taken at this clock edge |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Request beat accepted |
| req_sop | output | 1 | First beat of a write |
| req_eop | output | 1 | Last beat of a write |
| req_notify | output | 1 | The write is the completion notice |
| req_addr | output | 64 | Byte address of the write |
| req_len | output | 9 | Byte length of the write |
| req_data | output | 256 | Beat data |

## Verification
The properties assume that the FIFO keeps a word it has presented until that word is taken, that every entry length is a nonzero multiple of 32, and that the entry count never exceeds sixteen. The stimulus meets these conditions. The source lowers s_valid only after a transfer, the vector lengths are all multiples of 32, and the counts are at most three. Back-pressure is applied freely through rotating valid and ready patterns, which is allowed because the request channel makes no promise to keep req_valid high on its own.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_NOTE = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  localparam logic [7:0] RA_CTRL    = 8'h00;
  localparam logic [7:0] RA_COUNT   = 8'h01;
  localparam logic [7:0] RA_NOTE_LO = 8'h02;
  localparam logic [7:0] RA_NOTE_HI = 8'h03;
  localparam logic [7:0] RA_STATUS  = 8'h04;
  localparam logic [7:0] RA_LAT     = 8'h05;
  localparam int         NOTE_BYTES = 4;

  function automatic logic [1:0] status_code(input phase_t p);
    case (p)
      PH_IDLE: return 2'd0;
      PH_DONE: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // beats in the next burst: the smaller of what is left and the cap
  function automatic logic [31:0] clip_beats(input logic [31:0] rem, input logic [31:0] cap);
    return (rem < cap) ? rem : cap;
  endfunction

  function automatic logic in_table(input logic [7:0] a);
    return a[7:6] == 2'b10;
  endfunction

endpackage

// File: rtl/sgdma_addr_table.sv
module sgdma_addr_table #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 64,
  parameter int LEN_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        waddr,
  input  logic [31:0]       wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  input  logic [7:0]        pr_addr,
  output logic [31:0]       pr_data
);
  import sgdma_pkg::*;

  logic [ADDR_W-1:0] t_addr [ENTRIES];
  logic [LEN_W-1:0]  t_len  [ENTRIES];

  wire              w_hit = we && in_table(waddr);
  wire [IDX_W-1:0]  w_idx = waddr[IDX_W+1:2];
  wire [IDX_W-1:0]  r_idx = pr_addr[IDX_W+1:2];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_addr[i] <= '0;
        t_len[i]  <= '0;
      end else if (w_hit && w_idx == IDX_W'(i)) begin
        case (waddr[1:0])
          2'd0:    t_addr[i][31:0]       <= wdata;
          2'd1:    t_addr[i][ADDR_W-1:32] <= wdata[ADDR_W-33:0];
          2'd2:    t_len[i]              <= wdata[LEN_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = t_addr[rd_idx];
  assign rd_len  = t_len[rd_idx];

  always_comb begin
    case (pr_addr[1:0])
      2'd0:    pr_data = t_addr[r_idx][31:0];
      2'd1:    pr_data = 32'(t_addr[r_idx][ADDR_W-1:32]);
      2'd2:    pr_data = 32'(t_len[r_idx]);
      default: pr_data = '0;
    endcase
  end

endmodule

// File: rtl/sgdma_lat_timer.sv
module sgdma_lat_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  output logic [CNT_W-1:0] count,
  output logic             running
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (go) begin
      count   <= '0;
      running <= 1'b1;
    end else begin
      if (running) count <= count + 1'b1;
      if (halt)    running <= 1'b0;
    end
  end

endmodule

// File: rtl/sgdma_burst_engine.sv
module sgdma_burst_engine
  import sgdma_pkg::*;
#(
  parameter int ENTRIES         = 16,
  parameter int ADDR_W          = 64,
  parameter int LEN_W           = 32,
  parameter int DATA_W          = 256,
  parameter int MAX_BURST_BYTES = 256,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int BEAT_SH    = $clog2(BEAT_BYTES),
  localparam int MAX_BEATS  = MAX_BURST_BYTES / BEAT_BYTES,
  localparam int POS_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
  localparam int REM_W      = LEN_W - BEAT_SH + 1,
  localparam int RLEN_W     = $clog2(MAX_BURST_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [IDX_W:0]    ent_count,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [LEN_W-1:0]  ent_len,
  input  logic [ADDR_W-1:0] note_addr,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_sop,
  output logic              req_eop,
  output logic              req_notify,
  output logic [ADDR_W-1:0] req_addr,
  output logic [RLEN_W-1:0] req_len,
  output logic [DATA_W-1:0] req_data,
  output phase_t            phase,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              go
);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] cur_addr;
  logic [REM_W-1:0]  rem;
  logic [POS_W-1:0]  beat_pos;
  logic [31:0]       total;

  // named internal events
  logic [REM_W-1:0] burst_n, new_rem;
  logic beat_fire, pos_last, entry_last, cnt_last, note_fire;

  assign new_rem    = REM_W'(ent_len[LEN_W-1:BEAT_SH]) + REM_W'(|ent_len[BEAT_SH-1:0]);
  assign burst_n    = REM_W'(clip_beats(32'(rem), 32'(MAX_BEATS)));
  assign pos_last   = REM_W'(beat_pos) == burst_n - 1'b1;
  assign entry_last = rem == burst_n;
  assign cnt_last   = {1'b0, idx} == ent_count - 1'b1;
  assign go         = start_req && (phase == PH_IDLE || phase == PH_DONE);
  assign beat_fire  = s_valid && s_ready;
  assign note_fire  = (phase == PH_NOTE) && req_ready;
  assign rd_idx     = (phase == PH_DATA) ? idx + 1'b1 : '0;
  assign cur_idx    = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      idx      <= '0;
      cur_addr <= '0;
      rem      <= '0;
      beat_pos <= '0;
      total    <= '0;
    end else if (go) begin
      idx      <= '0;
      cur_addr <= ent_addr;
      rem      <= new_rem;
      beat_pos <= '0;
      total    <= '0;
      phase    <= (ent_count == '0) ? PH_NOTE : PH_DATA;
    end else if (beat_fire) begin
      total <= total + 32'(BEAT_BYTES);
      if (pos_last) begin
        beat_pos <= '0;
        if (entry_last) begin
          if (cnt_last) begin
            phase <= PH_NOTE;
          end else begin
            idx      <= idx + 1'b1;
            cur_addr <= ent_addr;
            rem      <= new_rem;
          end
        end else begin
          cur_addr <= cur_addr + (ADDR_W'(burst_n) << BEAT_SH);
          rem      <= rem - burst_n;
        end
      end else begin
        beat_pos <= beat_pos + 1'b1;
      end
    end else if (note_fire) begin
      phase <= PH_DONE;
    end
  end

  always_comb begin
    s_ready    = (phase == PH_DATA) && req_ready;
    req_notify = phase == PH_NOTE;
    req_valid  = (phase == PH_DATA) ? s_valid : req_notify;
    req_sop    = (phase == PH_DATA) ? (beat_pos == '0) : req_notify;
    req_eop    = (phase == PH_DATA) ? pos_last : req_notify;
    req_addr   = req_notify ? note_addr : cur_addr;
    req_len    = req_notify ? RLEN_W'(NOTE_BYTES) : (RLEN_W'(burst_n) << BEAT_SH);
    req_data   = req_notify ? DATA_W'(total) : s_data;
  end

endmodule

// File: rtl/sgdma_wr.sv
module sgdma_wr
  import sgdma_pkg::*;
#(
  parameter int ENTRIES         = 16,
  parameter int ADDR_W          = 64,
  parameter int LEN_W           = 32,
  parameter int DATA_W          = 256,
  parameter int MAX_BURST_BYTES = 256,
  parameter int CNT_W           = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RLEN_W = $clog2(MAX_BURST_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pio_we,
  input  logic [7:0]        pio_waddr,
  input  logic [31:0]       pio_wdata,
  input  logic [7:0]        pio_raddr,
  output logic [31:0]       pio_rdata,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_sop,
  output logic              req_eop,
  output logic              req_notify,
  output logic [ADDR_W-1:0] req_addr,
  output logic [RLEN_W-1:0] req_len,
  output logic [DATA_W-1:0] req_data
);

  logic [IDX_W:0]    ent_count;
  logic [ADDR_W-1:0] note_addr;
  logic [IDX_W-1:0]  rd_idx, cur_idx;
  logic [ADDR_W-1:0] ent_addr;
  logic [LEN_W-1:0]  ent_len;
  logic [31:0]       tab_rdata;
  logic [CNT_W-1:0]  lat_count;
  logic              lat_run, go;
  phase_t            phase;

  wire ctrl_wr   = pio_we && (pio_waddr == RA_CTRL);
  wire start_req = ctrl_wr && pio_wdata[0];
  wire stop_req  = ctrl_wr && pio_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_count <= '0;
      note_addr <= '0;
    end else if (pio_we) begin
      if (pio_waddr == RA_COUNT)   ent_count              <= pio_wdata[IDX_W:0];
      if (pio_waddr == RA_NOTE_LO) note_addr[31:0]        <= pio_wdata;
      if (pio_waddr == RA_NOTE_HI) note_addr[ADDR_W-1:32] <= pio_wdata[ADDR_W-33:0];
    end
  end

  sgdma_addr_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(pio_we), .waddr(pio_waddr), .wdata(pio_wdata),
    .rd_idx(rd_idx), .rd_addr(ent_addr), .rd_len(ent_len),
    .pr_addr(pio_raddr), .pr_data(tab_rdata)
  );

  sgdma_burst_engine #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .MAX_BURST_BYTES(MAX_BURST_BYTES)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ent_count(ent_count),
    .rd_idx(rd_idx), .ent_addr(ent_addr), .ent_len(ent_len), .note_addr(note_addr),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_sop(req_sop), .req_eop(req_eop),
    .req_notify(req_notify), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .phase(phase), .cur_idx(cur_idx), .go(go)
  );

  sgdma_lat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .halt(stop_req),
    .count(lat_count), .running(lat_run)
  );

  always_comb begin
    case (pio_raddr)
      RA_COUNT:   pio_rdata = 32'(ent_count);
      RA_NOTE_LO: pio_rdata = note_addr[31:0];
      RA_NOTE_HI: pio_rdata = 32'(note_addr[ADDR_W-1:32]);
      RA_STATUS:  pio_rdata = 32'({cur_idx, 6'b0, status_code(phase)});
      RA_LAT:     pio_rdata = 32'(lat_count);
      default:    pio_rdata = in_table(pio_raddr) ? tab_rdata : '0;
    endcase
  end

endmodule

// File: rtl/sgdma_wr_chk.sv
module sgdma_wr_chk
  import sgdma_pkg::*;
#(
  parameter int DATA_W          = 256,
  parameter int ADDR_W          = 64,
  parameter int MAX_BURST_BYTES = 256,
  parameter int IDX_W           = 4,
  parameter int CNT_W           = 32,
  localparam int BEAT_SH = $clog2(DATA_W / 8),
  localparam int RLEN_W  = $clog2(MAX_BURST_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_sop,
  input logic              req_eop,
  input logic              req_notify,
  input logic [ADDR_W-1:0] req_addr,
  input logic [RLEN_W-1:0] req_len,
  input logic [DATA_W-1:0] req_data,
  input phase_t            phase,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              go,
  input logic              start_req,
  input logic              lat_run,
  input logic [CNT_W-1:0]  lat_count
);

  logic [7:0] beat_cnt;
  logic       note_done;
  wire        dfire = req_valid && req_ready && !req_notify;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt  <= '0;
      note_done <= 1'b0;
    end else begin
      if (go) note_done <= 1'b0;
      else if (req_valid && req_ready && req_notify) note_done <= 1'b1;
      if (dfire) beat_cnt <= req_eop ? 8'd0 : beat_cnt + 8'd1;
    end
  end

  AST_BEAT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (req_valid && req_ready && !req_notify && req_data == s_data)); // R6
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_DATA) |-> !s_ready); // R6
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_notify) |-> (req_len != '0 && 32'(req_len) <= 32'(MAX_BURST_BYTES)
                                    && req_len[BEAT_SH-1:0] == '0)); // R4
  AST_BURST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (dfire && req_eop) |-> (((32'(beat_cnt) + 32'd1) << BEAT_SH) == 32'(req_len))); // R4
  AST_SOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dfire && beat_cnt == 8'd0) |-> req_sop); // R4
  AST_HOLD_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(req_addr) && $stable(req_len) && $stable(req_notify))); // R3
  AST_NO_DATA_AFTER_NOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> !note_done); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && phase == PH_DATA && !s_ready) |=> (phase == PH_DATA && $stable(cur_idx))); // R7
  AST_LAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (lat_run && lat_count == '0)); // R8
  AST_LAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_run && !go) |=> $stable(lat_count)); // R8

endmodule

bind sgdma_wr sgdma_wr_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_BURST_BYTES(MAX_BURST_BYTES),
  .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
  .req_valid(req_valid), .req_ready(req_ready), .req_sop(req_sop), .req_eop(req_eop),
  .req_notify(req_notify), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
  .phase(phase), .cur_idx(cur_idx), .go(go), .start_req(start_req),
  .lat_run(lat_run), .lat_count(lat_count)
);

// File: tb/sgdma_wr_bench.sv
module sgdma_wr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  // stimulus: entry count, lengths, valid/ready patterns; expected: burst count
  localparam int       V_CNT  [NV] = '{1, 2, 3, 3};
  localparam int       V_L0   [NV] = '{256, 512, 288, 64};
  localparam int       V_L1   [NV] = '{0, 96, 32, 64};
  localparam int       V_L2   [NV] = '{0, 0, 800, 64};
  localparam logic [7:0] V_VP [NV] = '{8'hFF, 8'hB7, 8'hEE, 8'h5A};
  localparam logic [7:0] V_RP [NV] = '{8'hFF, 8'hDB, 8'h7F, 8'h33};
  localparam int       V_EXPB [NV] = '{1, 3, 7, 3};

  logic clk = 1'b0, rst_n = 1'b0;
  logic pio_we = 1'b0;
  logic [7:0] pio_waddr = '0, pio_raddr = '0;
  logic [31:0] pio_wdata = '0, pio_rdata;
  logic [255:0] s_data = '0;
  logic s_valid = 1'b0, s_ready;
  logic req_valid, req_ready = 1'b0, req_sop, req_eop, req_notify;
  logic [63:0] req_addr;
  logic [8:0] req_len;
  logic [255:0] req_data;

  sgdma_wr u_sgdma_wr (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] vpat = 8'h00, rpat = 8'h00;
  int ph = 0;
  logic [31:0] seq = 0, exp_seq = 0;
  logic fire_n = 1'b0;
  logic [63:0] exp_a [64];
  int exp_l [64];
  int exp_n = 0, bi = 0, beats = 0, mism = 0, seq_err = 0, order_err = 0, note_cnt = 0, note_after = 0;
  logic [63:0] note_addr_seen;
  logic [31:0] note_data_seen;
  int note_len_seen;
  logic [63:0] tb_a [16];
  int tb_l [16];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // source and sink: inputs change just after the rising edge
  always @(posedge clk) begin
    #1;
    ph++;
    req_ready = rpat[ph % 8];
    if (fire_n) begin
      seq++;
      s_data = {224'b0, seq};
      s_valid = vpat[(ph + 3) % 8];
    end else if (!s_valid) begin
      s_valid = vpat[(ph + 3) % 8];
    end
  end

  // monitor at the falling edge
  always @(negedge clk) begin
    fire_n = s_valid && s_ready;
    if (rst_n && req_valid && req_ready) begin
      if (req_notify) begin
        note_cnt++;
        note_addr_seen = req_addr;
        note_data_seen = req_data[31:0];
        note_len_seen = int'(req_len);
        note_after = beats;
      end else begin
        if (note_cnt != 0) order_err++;
        if (req_data[31:0] != exp_seq) seq_err++;
        exp_seq++;
        beats++;
        if (req_sop) begin
          if (bi >= exp_n || req_addr != exp_a[bi] || int'(req_len) != exp_l[bi]) mism++;
          bi++;
        end
      end
    end
  end

  task automatic pio_write(input logic [7:0] a, input logic [31:0] d, output time t);
    @(posedge clk); #1;
    pio_we = 1'b1; pio_waddr = a; pio_wdata = d;
    @(posedge clk); t = $time; #1;
    pio_we = 1'b0;
  endtask

  task automatic pio_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    pio_raddr = a;
    #1 d = pio_rdata;
  endtask

  task automatic build_exp(input int cnt);
    exp_n = 0;
    for (int e = 0; e < cnt; e++) begin
      logic [63:0] a;
      int rem, b;
      a = tb_a[e];
      rem = tb_l[e];
      while (rem > 0) begin
        b = (rem > 256) ? 256 : rem;
        exp_a[exp_n] = a;
        exp_l[exp_n] = b;
        exp_n++;
        a += 64'(b);
        rem -= b;
      end
    end
  endtask

  task automatic clear_mon();
    bi = 0; beats = 0; mism = 0; seq_err = 0; order_err = 0; note_cnt = 0;
  endtask

  task automatic wait_note();
    int guard;
    guard = 0;
    while (note_cnt == 0 && guard < 4000) begin
      @(posedge clk);
      guard++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish_up();
  end

  initial begin
    time t0, t1, tx;
    logic [31:0] rd, rd2;
    logic [63:0] na;
    int cnt, bytes;

    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_valid after reset", 64'(req_valid), 0);
    chk("R1 s_ready after reset", 64'(s_ready), 0);
    pio_read(8'h04, rd);
    chk("R1 status after reset", 64'(rd), 0);
    pio_read(8'h05, rd);
    chk("R1 latency after reset", 64'(rd), 0);

    for (int v = 0; v < NV; v++) begin
      vpat = V_VP[v]; rpat = V_RP[v];
      cnt = V_CNT[v];
      tb_l[0] = V_L0[v]; tb_l[1] = V_L1[v]; tb_l[2] = V_L2[v];
      bytes = 0;
      pio_write(8'h01, 32'(cnt), tx);
      for (int e = 0; e < cnt; e++) begin
        tb_a[e] = {32'h0000_00A0 + 32'(e), 32'h0010_0000 + 32'(v) * 32'h1000 + 32'(e) * 32'h400};
        bytes += tb_l[e];
        pio_write(8'h80 + 8'(e * 4), tb_a[e][31:0], tx);
        pio_write(8'h81 + 8'(e * 4), tb_a[e][63:32], tx);
        pio_write(8'h82 + 8'(e * 4), 32'(tb_l[e]), tx);
      end
      na = 64'h0000_0FEE_0000_0040 + 64'(v * 8);
      pio_write(8'h02, na[31:0], tx);
      pio_write(8'h03, na[63:32], tx);
      if (v == 1) tb_a[1] = 64'h0000_0BAD_7700_0000;
      build_exp(cnt);
      clear_mon();
      pio_write(8'h00, 32'h1, t0);
      if (v == 1) begin
        pio_write(8'h84, tb_a[1][31:0], tx);
        pio_write(8'h85, tb_a[1][63:32], tx);
      end
      pio_read(8'h04, rd);
      chk($sformatf("R7 busy status v%0d", v), 64'(rd[1:0]), 1);
      if (v == 2) begin
        repeat (12) @(posedge clk);
        pio_write(8'h00, 32'h1, tx); // R7 start while busy must be ignored
      end
      wait_note();
      repeat (3) @(posedge clk);
      pio_write(8'h00, 32'h2, t1);
      chk($sformatf("R4 burst count v%0d", v), 64'(bi), 64'(V_EXPB[v]));
      chk($sformatf("R3 R2 burst address and length v%0d", v), 64'(mism), 0);
      chk($sformatf("R6 beats in order v%0d", v), 64'(seq_err), 0);
      chk($sformatf("R6 beat total v%0d", v), 64'(beats), 64'(bytes / 32));
      chk($sformatf("R5 single notify v%0d", v), 64'(note_cnt), 1);
      chk($sformatf("R5 notify address v%0d", v), note_addr_seen, na);
      chk($sformatf("R5 notify byte count v%0d", v), 64'(note_data_seen), 64'(bytes));
      chk($sformatf("R5 notify length and order v%0d", v),
          64'({note_len_seen == 4, note_after == beats, order_err == 0}), 64'h7);
      pio_read(8'h04, rd);
      chk($sformatf("R7 done status v%0d", v), 64'({rd[11:8], rd[1:0]}), 64'({4'(cnt - 1), 2'd2}));
      pio_read(8'h05, rd);
      chk($sformatf("R8 latency v%0d", v), 64'(rd), 64'((t1 - t0) / CLK_PERIOD));
      repeat (5) @(posedge clk);
      pio_read(8'h05, rd2);
      chk($sformatf("R8 latency held v%0d", v), 64'(rd2), 64'(rd));
      if (v == 1) begin
        pio_read(8'h85, rd);
        chk("R2 table readback", 64'(rd), 64'(tb_a[1][63:32]));
      end
    end

    // R9: no entries
    vpat = 8'hFF; rpat = 8'hFF;
    pio_write(8'h01, 32'h0, tx);
    exp_n = 0;
    clear_mon();
    pio_write(8'h00, 32'h1, t0);
    wait_note();
    chk("R9 no bursts", 64'(beats), 0);
    chk("R9 notify count zero", 64'({note_cnt[7:0], note_data_seen}), 64'({8'd1, 32'd0}));
    pio_read(8'h04, rd);
    chk("R9 done status", 64'(rd[11:0]), 64'h002);

    finish_up();
  end

endmodule